// File: doc/BRIEF.md
# Aliased Misc Control Register with Level Interrupt

This block holds one 64-bit control word on a simple register bus: byte address, read strobe, write strobe, write data and read data. The same stored word can be reached at three consecutive word offsets. The first offset overwrites the word. The second offset merges the write data into the word by AND, or in the clear variant it empties the word. The third offset merges by OR. The merge offsets let software set or drop single bits without a read-modify-write sequence, so two agents cannot race on the same word.

Only the upper sixteen bits of the word exist. The lower bits are dropped on every write and always read as zero. The top bit of the word drives a level interrupt line towards an interrupt controller.

Accesses are always full 64-bit words. The word offset is the byte address with its three low bits dropped. Read data arrives one cycle after the read strobe. Any access that lands outside the three offsets raises a one-cycle flag.

Top module: `misc_alias_reg`

## Requirements
- R1: Only bits 63..48 of any written value are kept, and bits 47..0 of read data are always zero.
- R2: `irq` equals bit 63 of the stored word. It changes at the same clock edge as the stored word, that is, in the cycle after the write that updated it.
- R3: A write to the base word offset stores the write data (masked as in R1). The base offset is 0x4020 when `CLEAR_VARIANT`=0 and 0x6080 when `CLEAR_VARIANT`=1.
- R4: With `CLEAR_VARIANT`=0, a write to word offset base+1 (0x4021) stores the current word AND the write data.
- R5: A write to word offset base+2 (0x4022 or 0x6082) stores the current word OR the write data.
- R6: With `CLEAR_VARIANT`=1, a write to word offset base+1 (0x6081) sets the whole word to zero, whatever the write data is.
- R7: A read of the base offset returns the stored word on `bus_rdata` one cycle later. A read of base+1, base+2 or any unmapped offset returns zero. `bus_rdata` is zero in every cycle that does not follow a read.
- R8: After reset the stored word, `irq`, `bus_rdata` and `unmapped` are all zero.
- R9: A write to an unmapped word offset leaves the stored word unchanged. Any read or write to an unmapped offset drives `unmapped` high for exactly the following cycle.
- R10: The word offset is `bus_addr` shifted right by 3, so the three low address bits have no effect on decoding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 64 | Write data |
| bus_rdata | output | 64 | Registered read data |
| irq | output | 1 | Level interrupt, copy of stored bit 63 |
| unmapped | output | 1 | One-cycle pulse after an unmapped access |

## Verification
The assertions take every input as a known value on each clock edge. They do not assume that reads and writes are exclusive. A write and a read in the same cycle are legal, and the read returns the word as it was before the write. The stimulus drives one access per cycle with a strobe held for a single cycle. It picks offsets at random among the three mapped offsets and a spread of unmapped offsets above them, and it fills the three low address bits with random values. Directed cases cover the interrupt rising and falling, an AND with zero, and a clear carrying all-ones data.

// File: rtl/misc_alias_reg.sv
module misc_alias_reg #(
  parameter int ADDR_W        = 32,
  parameter int KEEP_W        = 16,
  parameter bit CLEAR_VARIANT = 1'b0,
  parameter int BASE_PLAIN    = 'h4020,
  parameter int BASE_CLEAR    = 'h6080
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [63:0]       bus_wdata,
  output logic [63:0]       bus_rdata,
  output logic              irq,
  output logic              unmapped
);

  localparam int OFF_W  = ADDR_W - 3;
  localparam int LOW_W  = 64 - KEEP_W;
  localparam int BASE   = CLEAR_VARIANT ? BASE_CLEAR : BASE_PLAIN;
  localparam logic [OFF_W-1:0] OFF_BASE = OFF_W'(BASE);
  localparam logic [OFF_W-1:0] OFF_ALT  = OFF_W'(BASE + 1);
  localparam logic [OFF_W-1:0] OFF_OR   = OFF_W'(BASE + 2);

  logic [KEEP_W-1:0] field_q, field_d, alt_val;
  logic [OFF_W-1:0]  off;
  logic              hit_base, hit_alt, hit_or, mapped;
  logic [KEEP_W-1:0] wtop;

  assign off      = bus_addr[ADDR_W-1:3];
  assign hit_base = off == OFF_BASE;
  assign hit_alt  = off == OFF_ALT;
  assign hit_or   = off == OFF_OR;
  assign mapped   = hit_base | hit_alt | hit_or;
  assign wtop     = bus_wdata[63:LOW_W];

  generate
    if (CLEAR_VARIANT) begin : g_clear
      assign alt_val = '0;
    end else begin : g_and
      assign alt_val = field_q & wtop;
    end
  endgenerate

  always_comb begin
    field_d = field_q;
    if (bus_wr) begin
      if (hit_base)    field_d = wtop;
      else if (hit_alt) field_d = alt_val;
      else if (hit_or)  field_d = field_q | wtop;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      field_q   <= '0;
      irq       <= 1'b0;
      bus_rdata <= '0;
      unmapped  <= 1'b0;
    end else begin
      field_q   <= field_d;
      irq       <= field_d[KEEP_W-1];
      bus_rdata <= (bus_rd && hit_base) ? {field_q, {LOW_W{1'b0}}} : '0;
      unmapped  <= (bus_rd | bus_wr) & ~mapped;
    end
  end

  // R1
  low_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[LOW_W-1:0] == '0);

  // R2
  irq_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(bus_wr && mapped && !hit_alt));

  // R2
  irq_fall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(bus_wr && (hit_base || hit_alt)));

  // R7
  nonbase_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!(bus_rd && hit_base)) |-> bus_rdata == '0);

  // R9
  unmapped_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unmapped |-> $past((bus_rd || bus_wr) && !mapped));

  // R9
  unmapped_write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bus_wr && !mapped) |-> $stable(irq));

  generate
    if (CLEAR_VARIANT) begin : g_clear_chk
      // R6
      clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bus_wr && hit_alt) |-> !irq);
    end
  endgenerate

endmodule

// File: tb/misc_alias_reg_test.sv
module misc_alias_reg_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [31:0] addr [2];
  logic        wr [2];
  logic        rd [2];
  logic [63:0] wdata [2];
  logic [63:0] rdata [2];
  logic        irq [2];
  logic        unm [2];

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [15:0] model [2];

  misc_alias_reg #(.CLEAR_VARIANT(1'b0)) uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr[0]), .bus_wr(wr[0]), .bus_rd(rd[0]),
    .bus_wdata(wdata[0]), .bus_rdata(rdata[0]), .irq(irq[0]), .unmapped(unm[0]));

  misc_alias_reg #(.CLEAR_VARIANT(1'b1)) uut_clr (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr[1]), .bus_wr(wr[1]), .bus_rd(rd[1]),
    .bus_wdata(wdata[1]), .bus_rdata(rdata[1]), .irq(irq[1]), .unmapped(unm[1]));

  function automatic int base_of(int v);
    return v ? 'h6080 : 'h4020;
  endfunction

  function automatic logic [15:0] next_val(int v, logic [15:0] cur, int rel, logic [63:0] d);
    case (rel)
      0: return d[63:48];
      1: return v ? 16'h0 : (cur & d[63:48]);
      2: return cur | d[63:48];
      default: return cur;
    endcase
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_addr(int v, int rel);
    return 32'((base_of(v) + rel) << 3) | 32'($urandom % 8);
  endfunction

  task automatic do_write(int v, int rel, logic [63:0] d, string req);
    @(negedge clk);
    addr[v] = mk_addr(v, rel); wdata[v] = d; wr[v] = 1'b1;
    @(negedge clk);
    wr[v] = 1'b0;
    model[v] = next_val(v, model[v], rel, d);
    check({req, " irq"}, 64'(irq[v]), 64'(model[v][15]));
    check({req, " R9 flag"}, 64'(unm[v]), 64'(rel > 2));
  endtask

  task automatic do_read(int v, int rel, string req);
    @(negedge clk);
    addr[v] = mk_addr(v, rel); rd[v] = 1'b1;
    @(negedge clk);
    rd[v] = 1'b0;
    check({req, " R7 rdata"}, rdata[v], rel == 0 ? {model[v], 48'h0} : 64'h0);
    check({req, " R9 flag"}, 64'(unm[v]), 64'(rel > 2));
    @(negedge clk);
    check("R7 idle rdata", rdata[v], 64'h0);
    check("R9 flag one cycle", 64'(unm[v]), 64'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int v = 0; v < 2; v++) begin
      addr[v] = '0; wr[v] = 1'b0; rd[v] = 1'b0; wdata[v] = '0; model[v] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int v = 0; v < 2; v++) begin
      check("R8 rdata", rdata[v], 64'h0);
      check("R8 irq", 64'(irq[v]), 64'h0);
      check("R8 flag", 64'(unm[v]), 64'h0);
      do_read(v, 0, "R8 stored");
    end
    for (int v = 0; v < 2; v++) begin
      do_write(v, 0, 64'hFFFF_FFFF_FFFF_FFFF, "R1 R3 R2 direct all ones");
      do_read(v, 0, "R1 R3 mask");
      do_read(v, 1, "R7 alt read");
      do_read(v, 2, "R7 or read");
      do_write(v, 5, 64'h0, "R9 unmapped write");
      do_read(v, 0, "R9 unchanged");
      do_read(v, 7, "R9 unmapped read");
      do_write(v, 1, v ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h0, v ? "R6 clear" : "R4 and zero");
      do_read(v, 0, "R4 R6 result");
      do_write(v, 2, 64'h8000_0000_0000_0001, "R5 R2 or top");
      do_read(v, 0, "R5 R10 result");
    end
    for (int i = 0; i < 400; i++) begin
      int v = $urandom % 2;
      int op = $urandom % 6;
      int rel = (op < 3) ? op : 3 + int'($urandom % 40);
      logic [63:0] d = {$urandom, $urandom};
      if (op == 5) do_read(v, $urandom % 4, "R7 R10 random read");
      else do_write(v, rel, d, "R1 R2 R3 R4 R5 R6 R9 random write");
    end
    for (int v = 0; v < 2; v++) do_read(v, 0, "R1 final");
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule